// File: doc/BRIEF.md
# Page-Mode Read Interface Controller

This block is the synchronous read front end of a parallel nonvolatile memory array. A requester holds chip enable, output enable, a bus-width select and an address. The block answers with read data from an internal array model. The array is a computed pattern, so it needs no storage. The block also models the timing of page-mode memories. The first access into a page pays a long latency. Later accesses to any location of that open page return after a short latency.

A page is eight words, which is sixteen bytes. The bus is either 16 bits wide or 8 bits wide. In the 8-bit mode, a low-order lane bit below the word address picks one byte of the addressed word. Both latencies are parameters given in clock cycles. A one-cycle strobe marks each completed read. Whenever the bus is not enabled, the data pins read zero and a flag reports them as high-impedance.

Top module: `pgrd_ctrl`

## Requirements
- R1: After reset, `rd_valid` is 0. With both enables low, `rd_data` is 0 and `bus_hiz` is 1.
- R2: Whenever `chip_en` or `out_en` is 0, `bus_hiz` is 1 and `rd_data` is all zeros in the same cycle.
- R3: A read that opens a page completes in RAND_LAT cycles (default 7). This covers the first read after reset and the first read after chip enable returns. Inputs are presented before clock edge k and then held. `rd_valid` is then 1 for the cycle after edge k+RAND_LAT-1.
- R4: When a page is open, a read of any other location with the same page tag (`addr[WAW-1:3]`) completes in PAGE_LAT cycles (default 3), in any order. Two `rd_valid` pulses are never closer than PAGE_LAT edges.
- R5: A read whose page tag differs from the open page closes that page and takes RAND_LAT cycles.
- R6: Dropping `chip_en` for at least one cycle closes the page, so the next read takes RAND_LAT cycles. Dropping only `out_en` keeps the page open, and re-reading the same address then takes PAGE_LAT cycles.
- R7: The array word at word address w is the low 16 bits of (w * 40503 + 4660). In word mode (`byte_sel` = 0) this word appears on all of `rd_data`.
- R8: In byte mode (`byte_sel` = 1), `byte_lsb` = 0 returns bits 7:0 of the addressed word and `byte_lsb` = 1 returns bits 15:8. Either byte appears on `rd_data[7:0]`, and `rd_data[15:8]` is 0. A change of `byte_sel` or `byte_lsb` within the open page is an in-page read.
- R9: In word mode, `byte_lsb` is ignored. Toggling it starts no read, gives no `rd_valid`, and leaves `rd_data` unchanged.
- R10: `rd_valid` lasts exactly one cycle per read. Afterwards `rd_data` holds the read value for as long as the bus stays enabled and the inputs stay stable.
- R11: Changing the location before a read completes abandons that read. The latency is then counted from the new location. A read that missed the open page leaves no page open.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| chip_en | input | 1 | Chip enable, active high; low closes the page |
| out_en | input | 1 | Output enable, active high |
| byte_sel | input | 1 | 1 = 8-bit bus, 0 = 16-bit bus |
| byte_lsb | input | 1 | Byte lane bit below the word address (byte mode only) |
| addr | input | WAW (20) | Word address |
| rd_data | output | DW (16) | Read data, zero while not enabled or not yet ready |
| rd_valid | output | 1 | One-cycle strobe when read data is ready |
| bus_hiz | output | 1 | 1 while the data pins are modelled as high-impedance |

## Verification
The main read path is exercised with several distinct patterns:
- A cold first read.
- Scattered out-of-order reads inside one page.
- Width and lane switches within a page.
- A jump to a distant page.
- Output-enable and chip-enable interruptions.
- An address change in the middle of a long access.

Because each pattern's measured latency is compared with its expected value, the bench can tell whether the design charged the random latency or the in-page latency. It can therefore detect a page that stays open when it should close, or one that is lost when it should stay. The returned values are compared against the array formula and the lane rule, which separates low-byte, high-byte and word selection. Held-data and ignored-bit checks confirm that no read is started when none should be.

// File: rtl/pgrd_pkg.sv
package pgrd_pkg;

   // Bus width selection as seen on byte_sel.
   typedef enum logic {
      BUS_WORD = 1'b0,
      BUS_BYTE = 1'b1
   } bus_mode_e;

   // Array model (R7): every word is a pure function of its word address.
   function automatic logic [15:0] cell_word(input logic [31:0] waddr);
      return 16'(waddr * 32'd40503 + 32'd4660);
   endfunction

endpackage

// File: rtl/pgrd_lat_tmr.sv
// Countdown that fires one cycle-edge before it would reach zero.
// A load of L-1 taken at edge k fires at edge k+L-1 (R3, R4).
module pgrd_lat_tmr #(
   parameter int CW = 4
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          start,
   input  logic [CW-1:0] load,
   input  logic          abort,
   output logic          fire
);
   logic [CW-1:0] cnt_q;

   assign fire = (cnt_q == CW'(1)) && !start && !abort;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cnt_q <= '0;
      end else if (abort) begin
         cnt_q <= '0;
      end else if (start) begin
         cnt_q <= load;
      end else if (cnt_q != '0) begin
         cnt_q <= cnt_q - CW'(1);
      end
   end
endmodule

// File: rtl/pgrd_page_trk.sv
// Open-page register: one tag and a valid bit (R4, R5, R6, R11).
module pgrd_page_trk #(
   parameter int TAG_W = 17
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             close,
   input  logic             open_pg,
   input  logic [TAG_W-1:0] open_tag,
   input  logic [TAG_W-1:0] probe_tag,
   output logic             hit
);
   logic             open_q;
   logic [TAG_W-1:0] tag_q;

   assign hit = open_q && (tag_q == probe_tag);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         open_q <= 1'b0;
         tag_q  <= '0;
      end else if (close) begin
         open_q <= 1'b0;
      end else if (open_pg) begin
         open_q <= 1'b1;
         tag_q  <= open_tag;
      end
   end
endmodule

// File: rtl/pgrd_lane_sel.sv
// Word / byte formatting of one array word (R7, R8).
module pgrd_lane_sel #(
   parameter int DW = 16
) (
   input  logic                 byte_mode,
   input  logic                 lane_hi,
   input  logic [DW-1:0]        word_in,
   output logic [DW-1:0]        data_out
);
   localparam int NLANE = DW / 8;

   logic [7:0] lane [NLANE];
   logic [7:0] picked;

   for (genvar i = 0; i < NLANE; i++) begin : g_lane
      assign lane[i] = word_in[8*i +: 8];
   end

   assign picked = lane[lane_hi];

   always_comb begin
      if (byte_mode == pgrd_pkg::BUS_BYTE) begin
         data_out = {{(DW-8){1'b0}}, picked};
      end else begin
         data_out = word_in;
      end
   end
endmodule

// File: rtl/pgrd_ctrl.sv
module pgrd_ctrl #(
   parameter int WAW        = 20,
   parameter int DW         = 16,
   parameter int PAGE_WORDS = 8,
   parameter int RAND_LAT   = 7,
   parameter int PAGE_LAT   = 3
) (
   input  logic           clk,
   input  logic           rst_n,
   input  logic           chip_en,
   input  logic           out_en,
   input  logic           byte_sel,
   input  logic           byte_lsb,
   input  logic [WAW-1:0] addr,
   output logic [DW-1:0]  rd_data,
   output logic           rd_valid,
   output logic           bus_hiz
);
   localparam int OFF_W = $clog2(PAGE_WORDS);
   localparam int TAG_W = WAW - OFF_W;
   localparam int CW    = $clog2(RAND_LAT + 1) + 1;

   // Elaboration-time parameter checks
   if (DW != 16) begin : g_bad_dw
      $error("pgrd_ctrl: DW must be 16 (two byte lanes)");
   end
   if (PAGE_LAT < 2 || RAND_LAT < PAGE_LAT) begin : g_bad_lat
      $error("pgrd_ctrl: need 2 <= PAGE_LAT <= RAND_LAT");
   end
   if ((1 << OFF_W) != PAGE_WORDS || OFF_W < 1) begin : g_bad_page
      $error("pgrd_ctrl: PAGE_WORDS must be a power of two above 1");
   end
   if (WAW >= 32 || WAW <= OFF_W) begin : g_bad_waw
      $error("pgrd_ctrl: WAW out of range");
   end

   // Current location under service
   logic           bus_on;
   logic           lane_eff;
   logic           loc_vld_q;
   logic [WAW-1:0] cur_addr_q;
   logic           cur_lane_q;
   logic           cur_bsel_q;
   logic           new_acc;
   logic           pg_hit;
   logic           fire;
   logic [CW-1:0]  lat_load;
   logic [DW-1:0]  fmt_word;
   logic [DW-1:0]  fmt_data;
   logic [DW-1:0]  data_q;
   logic           have_q;
   logic           valid_q;

   assign bus_on   = chip_en & out_en;
   // R9: the lane bit counts only in byte mode
   assign lane_eff = byte_sel & byte_lsb;

   assign new_acc = bus_on &&
                    (!loc_vld_q || addr != cur_addr_q ||
                     lane_eff != cur_lane_q || byte_sel != cur_bsel_q);

   // R4/R5: in-page hit picks the short latency
   assign lat_load = pg_hit ? CW'(PAGE_LAT - 1) : CW'(RAND_LAT - 1);

   pgrd_page_trk #(.TAG_W(TAG_W)) u_page (
      .clk       (clk),
      .rst_n     (rst_n),
      .close     (!chip_en || (new_acc && !pg_hit)),
      .open_pg   (fire),
      .open_tag  (cur_addr_q[WAW-1:OFF_W]),
      .probe_tag (addr[WAW-1:OFF_W]),
      .hit       (pg_hit)
   );

   pgrd_lat_tmr #(.CW(CW)) u_tmr (
      .clk   (clk),
      .rst_n (rst_n),
      .start (new_acc),
      .load  (lat_load),
      .abort (!bus_on),
      .fire  (fire)
   );

   assign fmt_word = pgrd_pkg::cell_word({{(32-WAW){1'b0}}, cur_addr_q});

   pgrd_lane_sel #(.DW(DW)) u_lane (
      .byte_mode (cur_bsel_q),
      .lane_hi   (cur_lane_q),
      .word_in   (fmt_word),
      .data_out  (fmt_data)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         loc_vld_q  <= 1'b0;
         cur_addr_q <= '0;
         cur_lane_q <= 1'b0;
         cur_bsel_q <= 1'b0;
         have_q     <= 1'b0;
         data_q     <= '0;
         valid_q    <= 1'b0;
      end else begin
         valid_q <= fire;
         if (!bus_on) begin
            loc_vld_q <= 1'b0;
            have_q    <= 1'b0;
         end else if (new_acc) begin
            // R11: a new location abandons any read in flight
            loc_vld_q  <= 1'b1;
            cur_addr_q <= addr;
            cur_lane_q <= lane_eff;
            cur_bsel_q <= byte_sel;
            have_q     <= 1'b0;
         end else if (fire) begin
            have_q <= 1'b1;
            data_q <= fmt_data;
         end
      end
   end

   // R2: bus disabled drives zero and reports high-impedance
   assign bus_hiz  = !bus_on;
   assign rd_data  = (bus_on && have_q) ? data_q : '0;
   assign rd_valid = valid_q;
endmodule

// File: rtl/pgrd_ctrl_chk.sv
module pgrd_ctrl_chk #(
   parameter int WAW      = 20,
   parameter int DW       = 16,
   parameter int RAND_LAT = 7,
   parameter int PAGE_LAT = 3
) (
   input logic           clk,
   input logic           rst_n,
   input logic           chip_en,
   input logic           out_en,
   input logic           byte_sel,
   input logic [WAW-1:0] addr,
   input logic [DW-1:0]  rd_data,
   input logic           rd_valid,
   input logic           bus_hiz
);
   localparam int SW = $clog2(RAND_LAT + 2) + 1;

   logic [SW-1:0] since_ce;
   logic [SW-1:0] since_v;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         since_ce <= '0;
         since_v  <= SW'(RAND_LAT + 1);
      end else begin
         if (!chip_en) since_ce <= '0;
         else if (since_ce < SW'(RAND_LAT + 1)) since_ce <= since_ce + SW'(1);
         if (rd_valid) since_v <= '0;
         else if (since_v < SW'(RAND_LAT + 1)) since_v <= since_v + SW'(1);
      end
   end

   p_hiz_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
      bus_hiz |-> rd_data == '0);

   p_pulse_r10: assert property (@(posedge clk) disable iff (!rst_n)
      rd_valid |=> !rd_valid);

   p_valid_en_r3: assert property (@(posedge clk) disable iff (!rst_n)
      rd_valid |-> $past(chip_en && out_en));

   p_byte_upper_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_valid && $past(byte_sel)) |-> rd_data[DW-1:8] == '0);

   p_reopen_gap_r6: assert property (@(posedge clk) disable iff (!rst_n)
      rd_valid |-> since_ce >= SW'(RAND_LAT));

   p_min_gap_r4: assert property (@(posedge clk) disable iff (!rst_n)
      rd_valid |-> since_v >= SW'(PAGE_LAT - 1));

   logic unused_ok;
   assign unused_ok = ^addr;
endmodule

bind pgrd_ctrl pgrd_ctrl_chk #(
   .WAW(WAW), .DW(DW), .RAND_LAT(RAND_LAT), .PAGE_LAT(PAGE_LAT)
) u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .chip_en  (chip_en),
   .out_en   (out_en),
   .byte_sel (byte_sel),
   .addr     (addr),
   .rd_data  (rd_data),
   .rd_valid (rd_valid),
   .bus_hiz  (bus_hiz)
);

// File: tb/sim_pgrd_ctrl.sv
`timescale 1ns/100ps
module sim_pgrd_ctrl;
   localparam int RL = 7;
   localparam int PL = 3;

   logic        clk = 1'b0;
   logic        rst_n, chip_en, out_en, byte_sel, byte_lsb;
   logic [19:0] addr;
   logic [15:0] rd_data;
   logic        rd_valid, bus_hiz;

   always #2.5 clk = ~clk;

   pgrd_ctrl u0 (
      .clk(clk), .rst_n(rst_n), .chip_en(chip_en), .out_en(out_en),
      .byte_sel(byte_sel), .byte_lsb(byte_lsb), .addr(addr),
      .rd_data(rd_data), .rd_valid(rd_valid), .bus_hiz(bus_hiz)
   );

   int cyc = 0;
   always @(posedge clk) cyc <= cyc + 1;

   int n_chk = 0;
   int n_bad = 0;
   bit done  = 1'b0;
   logic [15:0] last_exp;

   logic [15:0] q_dat [$];
   int          q_cyc [$];
   string       q_req [$];

   // R7 array formula, R8 lane rule
   function automatic logic [15:0] model_word(input logic [19:0] w);
      return 16'({12'd0, w} * 32'd40503 + 32'd4660);
   endfunction

   function automatic logic [15:0] model_read(input logic [19:0] a,
                                              input logic l, input logic b);
      logic [15:0] w;
      w = model_word(a);
      if (b) return {8'h00, (l ? w[15:8] : w[7:0])};
      return w;
   endfunction

   task automatic check(input string req, input string what,
                        input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
      end
   endtask

   // Monitor: pops the scoreboard on every strobe
   always @(negedge clk) begin
      if (rst_n && rd_valid) begin
         if (q_dat.size() == 0) begin
            n_chk++;
            n_bad++;
            $display("FAIL R10 unexpected rd_valid: actual 1 expected 0");
         end else begin
            check(q_req[0], "latency cycle", cyc, q_cyc[0]);
            check(q_req[0], "data", {16'd0, rd_data}, {16'd0, q_dat[0]});
            void'(q_dat.pop_front());
            void'(q_cyc.pop_front());
            void'(q_req.pop_front());
         end
      end
   end

   // Driver: presents a read and pushes its expectation
   task automatic rd(input logic [19:0] a, input logic l, input logic b,
                     input int lat, input string req);
      @(negedge clk);
      chip_en  = 1'b1;
      out_en   = 1'b1;
      addr     = a;
      byte_lsb = l;
      byte_sel = b;
      last_exp = model_read(a, l, b);
      q_dat.push_back(last_exp);
      q_cyc.push_back(cyc + lat);
      q_req.push_back(req);
      for (int i = 0; i < lat + 20 && q_dat.size() != 0; i++) @(negedge clk);
      if (q_dat.size() != 0) begin
         check(req, "read completed", 0, 1);
         q_dat.delete();
         q_cyc.delete();
         q_req.delete();
      end
   endtask

   task automatic summary();
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
   endtask

   initial begin
      rst_n = 1'b0; chip_en = 1'b0; out_en = 1'b0;
      byte_sel = 1'b0; byte_lsb = 1'b0; addr = '0;
      repeat (4) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      #1;
      check("R1", "rd_valid", rd_valid, 0);
      check("R1", "rd_data", rd_data, 0);
      check("R1", "bus_hiz", bus_hiz, 1);

      rd(20'h00010, 0, 0, RL, "R3");
      rd(20'h00013, 0, 0, PL, "R4");
      rd(20'h00011, 0, 0, PL, "R4");
      rd(20'h00017, 0, 0, PL, "R4");

      repeat (4) @(negedge clk);
      check("R10", "held data", rd_data, last_exp);
      check("R10", "strobe low", rd_valid, 0);

      // R9: lane bit toggled in word mode
      @(negedge clk); byte_lsb = 1'b1;
      repeat (10) @(negedge clk);
      check("R9", "data unchanged", rd_data, last_exp);

      rd(20'h00015, 0, 1, PL, "R8");
      rd(20'h00015, 1, 1, PL, "R8");
      rd(20'h00010, 1, 1, PL, "R8");

      rd(20'h12345, 0, 0, RL, "R5");
      rd(20'h12340, 0, 0, PL, "R4");

      // R2 / R6: output enable only
      @(negedge clk); out_en = 1'b0;
      #1;
      check("R2", "bus_hiz oe low", bus_hiz, 1);
      check("R2", "zero data oe low", rd_data, 0);
      repeat (3) @(negedge clk);
      rd(20'h12340, 0, 0, PL, "R6");

      // R6: chip enable closes the page
      @(negedge clk); chip_en = 1'b0;
      #1;
      check("R2", "bus_hiz ce low", bus_hiz, 1);
      check("R2", "zero data ce low", rd_data, 0);
      repeat (3) @(negedge clk);
      rd(20'h12340, 0, 0, RL, "R6");

      // R11: abandon a random read midway
      @(negedge clk); addr = 20'h40000;
      repeat (3) @(negedge clk);
      rd(20'h40002, 0, 0, RL, "R11");
      rd(20'h40007, 0, 0, PL, "R4");

      // Top of the address space
      rd(20'hFFFFF, 1, 1, RL, "R8");
      rd(20'hFFFF8, 0, 0, PL, "R7");

      repeat (5) @(negedge clk);
      done = 1'b1;
      summary();
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         n_chk++;
         n_bad++;
         $display("FAIL watchdog: actual timeout expected completion");
         summary();
         $finish;
      end
   end
endmodule